// File: doc/BRIEF.md
# Cable Status and GPIO Interrupt Aggregator

This block merges two kinds of event into one interrupt line and one wake request. The first kind is a cable event. The block watches three status inputs: the cable-detect line of interface A, the cable-detect line of interface B, and a manual select switch. Any toggle of any of them, in either direction, sets one sticky cable-change flag. The second kind comes from a set of general-purpose inputs. Each one can be set as an edge source or a level source, active high or active low.

All status inputs first pass through a synchronizer. Sticky pending bits are cleared by writing a one into a clear mask. Level sources simply mirror their active level. The interrupt is the OR of every pending bit that is also enabled. The wake request follows the same set of sources. It can also be raised straight from the internal remote-wakeup line, which is merged into one fixed GPIO position.

Top module: `irq_agg`

## Requirements
- R1: After reset `pend_o`, `irq_o` and `wake_o` are all low. Detection stays off until the synchronizer and the previous-value registers hold real samples, so a status input that is already high when reset is released sets no pending bit.
- R2: A toggle of `cab_a_i`, rising or falling, sets the cable flag `pend_o[0]`.
- R3: A toggle of `cab_b_i`, rising or falling, sets `pend_o[0]`.
- R4: A toggle of `sel_sw_i` sets `pend_o[0]`.
- R5: When `clr_we_i` is high for one cycle, every sticky pending bit whose bit in `clr_mask_i` is one is cleared. Bit 0 of the mask is the cable flag and bit i+1 is GPIO i. Mask bits that are zero leave their pending bits unchanged.
- R6: If a new event reaches a pending bit in the same cycle as a clear of that bit, the bit stays set.
- R7: With `gpio_edge_i[i]`=1, GPIO i is an edge source. If `gpio_neg_i[i]`=0 a rising edge sets `pend_o[i+1]` and a falling edge does not. If `gpio_neg_i[i]`=1 only a falling edge sets it.
- R8: With `gpio_edge_i[i]`=0, `pend_o[i+1]` follows the active level of GPIO i. The active level is high when `gpio_neg_i[i]`=0 and low when it is 1. A clear write has no effect on it.
- R9: `irq_o` is high exactly when some bit of `pend_o` is high and its source is enabled (`cable_en_i` for bit 0, `gpio_en_i[i]` for bit i+1). A pending bit whose source is disabled is still shown on `pend_o` but raises neither `irq_o` nor `wake_o`.
- R10: `wake_o` is high whenever `irq_o` is high. It is also high whenever the synchronized `rwake_i` is high, whatever the enables are. `rwake_i` is ORed into GPIO input `RWAKE_IDX` before synchronization.
- R11: An edge or cable event shows on `pend_o` after `SYNC_STAGES`+1 rising clock edges have sampled the changed input. A level source shows after `SYNC_STAGES` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cab_a_i | input | 1 | Interface A cable-detect status |
| cab_b_i | input | 1 | Interface B cable-detect status |
| sel_sw_i | input | 1 | Manual select-switch status |
| gpio_i | input | N_GPIO | General-purpose interrupt inputs |
| rwake_i | input | 1 | Internal remote-wakeup request |
| cable_en_i | input | 1 | Enable for the cable-change flag |
| gpio_en_i | input | N_GPIO | Per-GPIO interrupt enable |
| gpio_edge_i | input | N_GPIO | Per-GPIO mode: 1 edge, 0 level |
| gpio_neg_i | input | N_GPIO | Per-GPIO polarity: 1 falling or active low |
| clr_we_i | input | 1 | Clear strobe |
| clr_mask_i | input | N_GPIO+1 | Write-one-to-clear mask (bit 0 cable, bit i+1 GPIO i) |
| pend_o | output | N_GPIO+1 | Pending bits (bit 0 cable, bit i+1 GPIO i) |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
The bench uses the default parameters: eight GPIOs, a two-stage synchronizer and remote wakeup on GPIO 5. Eight inputs are enough to cover all four trigger combinations on enabled pins, and to leave spare disabled pins that show pending-without-interrupt. With a remote-wakeup index of 5, the merged wake line lands on a pin that can be switched between disabled and enabled. Two stages give exact latency checks of two edges for level sources and three edges for edge sources. A two-stage synchronizer also makes the clear-against-event collision reachable in one cycle that the bench can pin down.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // number of cable-style status inputs watched for toggles
    localparam int unsigned CABLE_N = 3;

    // state of one GPIO source cell
    typedef struct packed {
        logic prev;
        logic pend;
    } gpio_st_t;

    // state of the cable-change detector
    typedef struct packed {
        logic [CABLE_N-1:0] prev;
        logic               pend;
    } cable_st_t;

    // map a raw sample to "active" according to polarity
    function automatic logic active_lvl(input logic smp, input logic neg);
        return smp ^ neg;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int unsigned k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_agg_gpio_src.sv
module irq_agg_gpio_src
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic smp_i,
    input  logic en_i,
    input  logic edge_i,
    input  logic neg_i,
    input  logic clr_i,
    output logic pend_o,
    output logic act_o
);

    gpio_st_t st_d, st_q;
    logic     now_act;
    logic     was_act;
    logic     hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp_i;
        now_act   = active_lvl(smp_i, neg_i);
        was_act   = active_lvl(st_q.prev, neg_i);
        // an edge toward the active level, only once samples are real
        hit       = armed_i & now_act & ~was_act;
        if (edge_i) begin
            // a new event wins over a clear in the same cycle
            st_d.pend = (st_q.pend & ~clr_i) | hit;
        end else begin
            st_d.pend = 1'b0;
        end
        pend_o = edge_i ? st_q.pend : (armed_i & now_act);
        act_o  = pend_o & en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_agg_cable.sv
module irq_agg_cable
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               armed_i,
    input  logic [CABLE_N-1:0] smp_i,
    input  logic               clr_i,
    output logic               pend_o
);

    cable_st_t st_d, st_q;
    logic      changed;

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp_i;
        // any toggle of any watched input, either direction
        changed   = armed_i & (|(smp_i ^ st_q.prev));
        st_d.pend = (st_q.pend & ~clr_i) | changed;
        pend_o    = st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_GPIO      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RWAKE_IDX   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cab_a_i,
    input  logic              cab_b_i,
    input  logic              sel_sw_i,
    input  logic [N_GPIO-1:0] gpio_i,
    input  logic              rwake_i,
    input  logic              cable_en_i,
    input  logic [N_GPIO-1:0] gpio_en_i,
    input  logic [N_GPIO-1:0] gpio_edge_i,
    input  logic [N_GPIO-1:0] gpio_neg_i,
    input  logic              clr_we_i,
    input  logic [N_GPIO:0]   clr_mask_i,
    output logic [N_GPIO:0]   pend_o,
    output logic              irq_o,
    output logic              wake_o
);

    localparam int unsigned SYNC_W    = CABLE_N + N_GPIO + 1;
    localparam int unsigned ARM_LIMIT = SYNC_STAGES + 1;
    localparam int unsigned ARM_W     = $clog2(ARM_LIMIT + 1);

    logic [N_GPIO-1:0] gpio_eff;
    logic [SYNC_W-1:0] raw_vec, smp_vec;
    logic [CABLE_N-1:0] cab_smp;
    logic [N_GPIO-1:0] gpio_smp;
    logic              rwake_smp;
    logic [ARM_W-1:0]  arm_d, arm_q;
    logic              armed;
    logic [N_GPIO:0]   act_vec;
    logic [N_GPIO:0]   clr_vec;

    // merge the remote-wakeup line into its GPIO position
    generate
        if (RWAKE_IDX < N_GPIO) begin : g_rwake_merge
            always_comb begin
                gpio_eff            = gpio_i;
                gpio_eff[RWAKE_IDX] = gpio_i[RWAKE_IDX] | rwake_i;
            end
        end else begin : g_rwake_none
            assign gpio_eff = gpio_i;
        end
    endgenerate

    assign raw_vec = {rwake_i, gpio_eff, sel_sw_i, cab_b_i, cab_a_i};

    irq_agg_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (smp_vec)
    );

    assign cab_smp   = smp_vec[CABLE_N-1:0];
    assign gpio_smp  = smp_vec[CABLE_N +: N_GPIO];
    assign rwake_smp = smp_vec[SYNC_W-1];

    // arming counter: detection waits until the sync chain and the
    // previous-value registers hold post-reset samples
    always_comb begin
        armed = (arm_q == ARM_W'(ARM_LIMIT));
        arm_d = armed ? arm_q : arm_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign clr_vec = clr_we_i ? clr_mask_i : '0;

    irq_agg_cable u_cable (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_i (armed),
        .smp_i   (cab_smp),
        .clr_i   (clr_vec[0]),
        .pend_o  (pend_o[0])
    );

    assign act_vec[0] = pend_o[0] & cable_en_i;

    generate
        for (genvar gi = 0; gi < N_GPIO; gi++) begin : g_src
            irq_agg_gpio_src u_src (
                .clk     (clk),
                .rst_n   (rst_n),
                .armed_i (armed),
                .smp_i   (gpio_smp[gi]),
                .en_i    (gpio_en_i[gi]),
                .edge_i  (gpio_edge_i[gi]),
                .neg_i   (gpio_neg_i[gi]),
                .clr_i   (clr_vec[gi+1]),
                .pend_o  (pend_o[gi+1]),
                .act_o   (act_vec[gi+1])
            );
        end
    endgenerate

    assign irq_o  = |act_vec;
    assign wake_o = irq_o | (armed & rwake_smp);

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int unsigned N_GPIO = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              armed_i,
    input logic              cable_en_i,
    input logic [N_GPIO-1:0] gpio_en_i,
    input logic              clr_we_i,
    input logic [N_GPIO:0]   clr_mask_i,
    input logic [N_GPIO:0]   pend_i,
    input logic              irq_i,
    input logic              wake_i
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (pend_i == '0 && !irq_i && !wake_i);
        end
    end

    // R1
    cable_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_i[0]) |-> $past(armed_i));

    // R5
    cable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_i[0]) && !($past(clr_we_i) && $past(clr_mask_i[0]))) |-> pend_i[0]);

    // R9
    all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cable_en_i && gpio_en_i == '0) |-> !irq_i);

    // R9
    cable_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i[0] && cable_en_i) |-> irq_i);

    // R10
    wake_covers_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> wake_i);

endmodule

bind irq_agg irq_agg_chk #(.N_GPIO(N_GPIO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed_i    (armed),
    .cable_en_i (cable_en_i),
    .gpio_en_i  (gpio_en_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .pend_i     (pend_o),
    .irq_i      (irq_o),
    .wake_i     (wake_o)
);

// File: tb/irq_agg_bench.sv
module irq_agg_bench;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NG         = 8;
    localparam int unsigned NV         = 19;

    typedef struct packed {
        logic       a;
        logic       b;
        logic       s;
        logic [7:0] g;
        logic [8:0] clr;
        logic [8:0] pend;
        logic       irq;
        logic       wake;
        logic [7:0] req;
    } vec_t;

    // configuration: g0 rising edge, g1 falling edge, g2 level high,
    // g3 level low, g4..g7 level high but disabled
    localparam logic [7:0] CFG_EN   = 8'h0F;
    localparam logic [7:0] CFG_EDGE = 8'h03;
    localparam logic [7:0] CFG_NEG  = 8'h0A;

    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,8'h08,9'h000,9'h001,1'b1,1'b1,8'd2},  // R2 cab A falls
        '{1'b0,1'b0,1'b0,8'h08,9'h001,9'h000,1'b0,1'b0,8'd5},  // R5 clear cable
        '{1'b0,1'b1,1'b0,8'h08,9'h000,9'h001,1'b1,1'b1,8'd3},  // R3 cab B rises
        '{1'b0,1'b1,1'b0,8'h08,9'h1FE,9'h001,1'b1,1'b1,8'd5},  // R5 other bits only
        '{1'b0,1'b1,1'b0,8'h08,9'h001,9'h000,1'b0,1'b0,8'd5},  // R5
        '{1'b0,1'b1,1'b1,8'h08,9'h000,9'h001,1'b1,1'b1,8'd4},  // R4 switch
        '{1'b0,1'b1,1'b1,8'h08,9'h001,9'h000,1'b0,1'b0,8'd5},  // R5
        '{1'b0,1'b1,1'b1,8'h09,9'h000,9'h002,1'b1,1'b1,8'd7},  // R7 g0 rise
        '{1'b0,1'b1,1'b1,8'h08,9'h002,9'h000,1'b0,1'b0,8'd7},  // R7 g0 fall ignored
        '{1'b0,1'b1,1'b1,8'h0A,9'h000,9'h000,1'b0,1'b0,8'd7},  // R7 g1 rise ignored
        '{1'b0,1'b1,1'b1,8'h08,9'h000,9'h004,1'b1,1'b1,8'd7},  // R7 g1 fall
        '{1'b0,1'b1,1'b1,8'h08,9'h004,9'h000,1'b0,1'b0,8'd5},  // R5
        '{1'b0,1'b1,1'b1,8'h0C,9'h000,9'h008,1'b1,1'b1,8'd8},  // R8 g2 high
        '{1'b0,1'b1,1'b1,8'h0C,9'h008,9'h008,1'b1,1'b1,8'd8},  // R8 clear ignored
        '{1'b0,1'b1,1'b1,8'h08,9'h000,9'h000,1'b0,1'b0,8'd8},  // R8
        '{1'b0,1'b1,1'b1,8'h00,9'h000,9'h010,1'b1,1'b1,8'd8},  // R8 g3 low
        '{1'b0,1'b1,1'b1,8'h08,9'h000,9'h000,1'b0,1'b0,8'd8},  // R8
        '{1'b0,1'b1,1'b1,8'h18,9'h000,9'h020,1'b0,1'b0,8'd9},  // R9 disabled g4
        '{1'b0,1'b1,1'b1,8'h08,9'h000,9'h000,1'b0,1'b0,8'd9}   // R9
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cab_a, cab_b, sel_sw, rwake, cable_en, clr_we;
    logic [NG-1:0] gpio, g_en, g_edge, g_neg;
    logic [NG:0]   clr_mask;
    logic [NG:0]   pend;
    logic          irq, wake;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg u_irq_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cab_a_i     (cab_a),
        .cab_b_i     (cab_b),
        .sel_sw_i    (sel_sw),
        .gpio_i      (gpio),
        .rwake_i     (rwake),
        .cable_en_i  (cable_en),
        .gpio_en_i   (g_en),
        .gpio_edge_i (g_edge),
        .gpio_neg_i  (g_neg),
        .clr_we_i    (clr_we),
        .clr_mask_i  (clr_mask),
        .pend_o      (pend),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got pend/irq/wake %h, expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_pulse(input logic [NG:0] m);
        clr_we   = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_we   = 1'b0;
        clr_mask = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        cab_a    = 1'b1;   // already high at reset release
        cab_b    = 1'b0;
        sel_sw   = 1'b0;
        gpio     = 8'h08;
        rwake    = 1'b0;
        cable_en = 1'b1;
        g_en     = CFG_EN;
        g_edge   = CFG_EDGE;
        g_neg    = CFG_NEG;
        clr_we   = 1'b0;
        clr_mask = '0;
        cycles(3);
        rst_n = 1'b1;
        cycles(6);
        // R1: quiet after reset, no event from the initial high input
        check("R1", {pend, irq, wake}, {9'h000, 1'b0, 1'b0});

        for (int v = 0; v < NV; v++) begin
            cab_a  = VEC[v].a;
            cab_b  = VEC[v].b;
            sel_sw = VEC[v].s;
            gpio   = VEC[v].g;
            if (VEC[v].clr != '0) clear_pulse(VEC[v].clr);
            else @(negedge clk);
            cycles(4);
            check($sformatf("R%0d vec %0d", VEC[v].req, v), {pend, irq, wake},
                  {VEC[v].pend, VEC[v].irq, VEC[v].wake});
        end

        // R11: edge latency of SYNC_STAGES+1 edges
        cab_a = 1'b1;
        cycles(2);
        check("R11 early", {pend, irq, wake}, {9'h000, 1'b0, 1'b0});
        cycles(1);
        check("R11 on time", {pend, irq, wake}, {9'h001, 1'b1, 1'b1});

        // R6: event in the same cycle as the clear keeps the bit
        cab_b = 1'b0;
        cycles(2);
        clr_we   = 1'b1;
        clr_mask = 9'h001;
        @(negedge clk);
        clr_we   = 1'b0;
        clr_mask = '0;
        check("R6", {pend, irq, wake}, {9'h001, 1'b1, 1'b1});
        cycles(3);
        clear_pulse(9'h001);
        cycles(1);
        check("R5 after R6", {pend, irq, wake}, {9'h000, 1'b0, 1'b0});

        // R9: disabled cable source pends but stays silent
        cable_en = 1'b0;
        sel_sw   = 1'b0;
        cycles(4);
        check("R9 cable off", {pend, irq, wake}, {9'h001, 1'b0, 1'b0});
        cable_en = 1'b1;
        cycles(1);
        check("R9 cable on", {pend, irq, wake}, {9'h001, 1'b1, 1'b1});
        clear_pulse(9'h001);
        cycles(1);

        // R10: remote wakeup raises wake even with its GPIO disabled
        rwake = 1'b1;
        cycles(4);
        check("R10 rwake", {pend, irq, wake}, {9'h040, 1'b0, 1'b1});
        g_en = CFG_EN | 8'h20;
        cycles(1);
        check("R10 rwake enabled", {pend, irq, wake}, {9'h040, 1'b1, 1'b1});
        rwake = 1'b0;
        g_en  = CFG_EN;
        cycles(4);
        check("R10 rwake gone", {pend, irq, wake}, {9'h000, 1'b0, 1'b0});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule